// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block sits between a narrow host data port and the local packet memory of a network controller. Software first loads a 16-bit remote address and a 16-bit remaining byte count, one byte at a time. Each strobe on the data port then moves one beat between the host and memory. A beat is 1 byte in byte mode, 2 bytes in word mode, or 4 bytes when the host makes a 32-bit access. After each beat the engine advances the address and decrements the count. It keeps the address inside the receive ring by folding it from the ring end back to the ring start.

When the count runs out, the engine raises a one-cycle completion pulse that feeds the interrupt status logic. The same pulse is raised when a remote read or write command is issued while the count is already zero. Only two regions of the memory map are backed by storage: a small low area and a large upper window. Writes outside these regions are dropped. Reads outside them return all-ones at the width of the access.

Each access is a single-cycle strobe. The memory port and the host read data are combinational in that cycle, and the new address and count appear after the next clock edge.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset, the current address and the remaining count are both zero, `dmaDone` is low, and no memory write is driven.
- R2: The beat size is 4 bytes when `hostWide32` is high. Otherwise it is 2 bytes when `cfgWordMode` is high, and 1 byte when both are low. After an accepted access, the address grows by the beat size and the count shrinks by it.
- R3: For 2-byte and 4-byte beats, bit 0 of `memAddr` is forced to zero. Byte lane i (bits 8i+7..8i) of `memWrData`, `memRdData` and `hostRdData` is the byte at `memAddr`+i. `memByteEn` is 0001, 0011 or 1111 for beats of 1, 2 or 4 bytes.
- R4: A host write that arrives while the count is zero has no effect: no memory write, no change of address or count, and no completion pulse.
- R5: If the advanced address equals `stopPage`×256, the address is reloaded with `startPage`×256 instead.
- R6: If the count is not above the beat size, an access sets the count to zero and `dmaDone` is high for exactly the following cycle. Otherwise the count drops by the beat size and no pulse is given.
- R7: A `cmdStart` strobe while the count is zero raises `dmaDone` in the following cycle. A `cmdStart` strobe with a nonzero count does not.
- R8: The valid region is the aligned addresses below 32, plus those from 16384 up to 49151. Outside it, writes assert no `memWrEn` and reads return 0xFF, 0xFFFF or 0xFFFFFFFF (zero-extended). The address and count still advance.
- R9: The four load strobes each replace one byte (low or high) of the address or of the count, and leave the other byte unchanged.
- R10: A host read while the count is zero still performs the access and advances the address. The count stays zero and `dmaDone` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostRd | input | 1 | Data port read strobe, one cycle per beat |
| hostWr | input | 1 | Data port write strobe, one cycle per beat |
| hostWide32 | input | 1 | Current access is a 32-bit access |
| hostWrData | input | 32 | Write data from the host, lane 0 lowest |
| hostRdData | output | 32 | Read data to the host, valid while `hostRd` is high |
| cfgWordMode | input | 1 | 2-byte beats when high, 1-byte beats when low |
| startPage | input | 8 | First page of the ring |
| stopPage | input | 8 | Page just past the ring end |
| regData | input | 8 | Byte value for the load strobes |
| addrLoLd | input | 1 | Load the low address byte |
| addrHiLd | input | 1 | Load the high address byte |
| cntLoLd | input | 1 | Load the low count byte |
| cntHiLd | input | 1 | Load the high count byte |
| cmdStart | input | 1 | A remote read or write command was issued |
| memAddr | output | 16 | Aligned byte address of the beat |
| memRdEn | output | 1 | Memory read in the valid region |
| memWrEn | output | 1 | Memory write in the valid region |
| memByteEn | output | 4 | Active byte lanes of the beat |
| memWrData | output | 32 | Write data to memory, little-endian lanes |
| memRdData | input | 32 | Combinational read data from memory at `memAddr` |
| curAddr | output | 16 | Current remote address |
| curCount | output | 16 | Remaining byte count |
| dmaDone | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after the points where the ring end and the region edges meet the beat size.

- A wide access at an odd address must use the even address while the register still grows from the odd value. A design that aligned the register itself would end up one byte off.
- Beats that land exactly on the stop address must fold back to the ring start. A design that compared with greater-or-equal, or checked before adding, would fold at the wrong point or never fold.
- A count smaller than the beat, and a count of zero, must both saturate to zero with a pulse. A design that subtracted blindly would wrap to a huge count.
- A zero-count write must be dropped, while a zero-count read is still performed. Swapping these two cases would lose data or stall the read side.
- Accesses just below 16384 and just at 49152 must be refused. An off-by-one in the region test would corrupt or expose unbacked memory.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } xfer_size_e;

  // Strobes from the control to the datapath, valid for one cycle
  typedef struct packed {
    logic       advance;    // update address and count at the next edge
    logic       rdAccess;   // accepted read beat
    logic       wrAccess;   // accepted write beat
    logic       lastBeat;   // remaining count fits into this beat
    xfer_size_e size;       // beat width
  } rdma_strobe_t;

  function automatic logic [2:0] xferBytes(input xfer_size_e s);
    case (s)
      SZ_HALF: xferBytes = 3'd2;
      SZ_WORD: xferBytes = 3'd4;
      default: xferBytes = 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
  import rdma_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic              hostWide32,
  input  logic              cfgWordMode,
  input  logic              cmdStart,
  input  logic              anyLoad,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic [ADDR_W-1:0] curCount,
  output rdma_strobe_t      strb,
  output logic              dmaDone
);

  xfer_size_e        sizeSel;
  logic [ADDR_W-1:0] beatBytes;
  logic              countZero;
  logic              wrOk;
  logic              doneSet;

  always_comb begin
    if (hostWide32)       sizeSel = SZ_WORD;
    else if (cfgWordMode) sizeSel = SZ_HALF;
    else                  sizeSel = SZ_BYTE;
  end

  assign beatBytes = {{(ADDR_W-3){1'b0}}, xferBytes(sizeSel)};
  assign countZero = (curCount == '0);
  // writes stall once the count is used up; reads always go through
  assign wrOk      = hostWr && !countZero;

  always_comb begin
    strb          = '0;
    strb.size     = sizeSel;
    strb.advance  = !anyLoad && (hostRd || wrOk);
    strb.rdAccess = !anyLoad && hostRd;
    strb.wrAccess = !anyLoad && wrOk && !hostRd;
    strb.lastBeat = (curCount <= beatBytes);
  end

  assign doneSet = (strb.advance && strb.lastBeat) || (cmdStart && countZero);

  always_ff @(posedge clk) begin
    if (!rstN) dmaDone <= 1'b0;
    else       dmaDone <= doneSet;
  end

  AST_ZERO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && !hostRd && !anyLoad && curCount == '0)
      |=> (curAddr == $past(curAddr) && curCount == '0 && !dmaDone)) // R4
    else $error("zero-count write changed state");

  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    dmaDone |-> $past(hostRd || hostWr || cmdStart)) // R7
    else $error("completion pulse without access or command");

endmodule

// File: rtl/rdma_datapath.sv
module rdma_datapath
  import rdma_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 32,
  parameter int LOW_WIN_END  = 32,
  parameter int WIN_BASE     = 16384,
  parameter int WIN_END      = 49152
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdma_strobe_t      strb,
  input  logic              hostRd,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic [ADDR_W-9:0] startPage,
  input  logic [ADDR_W-9:0] stopPage,
  input  logic [7:0]        regData,
  input  logic              addrLoLd,
  input  logic              addrHiLd,
  input  logic              cntLoLd,
  input  logic              cntHiLd,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [DATA_W/8-1:0] memByteEn,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] curCount
);

  localparam int LANES = DATA_W / 8;
  localparam int HI_W  = ADDR_W - 8;

  logic [ADDR_W-1:0] startAddr;
  logic [ADDR_W-1:0] stopAddr;
  logic [ADDR_W-1:0] beatBytes;
  logic [ADDR_W-1:0] nextAddr;
  logic [ADDR_W-1:0] wrapAddr;
  logic [ADDR_W-1:0] nextCount;
  logic [2:0]        nb;
  logic              inWin;
  logic              anyLoad;

  assign startAddr = {startPage, 8'h00};
  assign stopAddr  = {stopPage, 8'h00};
  assign nb        = xferBytes(strb.size);
  assign beatBytes = {{(ADDR_W-3){1'b0}}, nb};

  // wide beats hit the even address; the register keeps its own value
  assign memAddr = (strb.size == SZ_BYTE) ? curAddr : {curAddr[ADDR_W-1:1], 1'b0};

  assign inWin = (32'(memAddr) < LOW_WIN_END) ||
                 ((32'(memAddr) >= WIN_BASE) && (32'(memAddr) < WIN_END));

  assign memWrEn = strb.wrAccess && inWin;
  assign memRdEn = strb.rdAccess && inWin;

  assign nextAddr  = curAddr + beatBytes;
  assign wrapAddr  = (nextAddr == stopAddr) ? startAddr : nextAddr;
  assign nextCount = strb.lastBeat ? '0 : (curCount - beatBytes);
  assign anyLoad   = addrLoLd || addrHiLd || cntLoLd || cntHiLd;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic laneOn;
    assign laneOn = (32'(g) < 32'(nb));
    assign memByteEn[g] = laneOn && (strb.rdAccess || strb.wrAccess);
    assign memWrData[g*8 +: 8] = laneOn ? hostWrData[g*8 +: 8] : 8'h00;
    assign hostRdData[g*8 +: 8] = (hostRd && laneOn)
                                  ? (inWin ? memRdData[g*8 +: 8] : 8'hFF)
                                  : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      curCount <= '0;
    end else if (anyLoad) begin
      if (addrLoLd) curAddr[7:0]         <= regData;
      if (addrHiLd) curAddr[ADDR_W-1:8]  <= regData[HI_W-1:0];
      if (cntLoLd)  curCount[7:0]        <= regData;
      if (cntHiLd)  curCount[ADDR_W-1:8] <= regData[HI_W-1:0];
    end else if (strb.advance) begin
      curAddr  <= wrapAddr;
      curCount <= nextCount;
    end
  end

  AST_RING_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !anyLoad && nextAddr == stopAddr) |=> (curAddr == $past(startAddr))) // R5
    else $error("ring end not folded to start");

  AST_COUNT_FALLS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !anyLoad) |=> (curCount == '0 || curCount < $past(curCount))) // R6
    else $error("count did not fall");

  AST_WIDE_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    ((memRdEn || memWrEn) && memByteEn != 4'b0001) |-> !memAddr[0]) // R3
    else $error("wide beat at odd address");

  AST_FILL_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdAccess && !memRdEn) |-> (hostRdData[7:0] == 8'hFF)) // R8
    else $error("out-of-region read not filled");

endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
  import rdma_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int LOW_WIN_END = 32,
  parameter int WIN_BASE    = 16384,
  parameter int WIN_END     = 49152
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic              hostWide32,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              cfgWordMode,
  input  logic [ADDR_W-9:0] startPage,
  input  logic [ADDR_W-9:0] stopPage,
  input  logic [7:0]        regData,
  input  logic              addrLoLd,
  input  logic              addrHiLd,
  input  logic              cntLoLd,
  input  logic              cntHiLd,
  input  logic              cmdStart,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [DATA_W/8-1:0] memByteEn,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] curCount,
  output logic              dmaDone
);

  rdma_strobe_t strb;
  logic         anyLoad;

  assign anyLoad = addrLoLd || addrHiLd || cntLoLd || cntHiLd;

  rdma_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostRd     (hostRd),
    .hostWr     (hostWr),
    .hostWide32 (hostWide32),
    .cfgWordMode(cfgWordMode),
    .cmdStart   (cmdStart),
    .anyLoad    (anyLoad),
    .curAddr    (curAddr),
    .curCount   (curCount),
    .strb       (strb),
    .dmaDone    (dmaDone)
  );

  rdma_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .LOW_WIN_END(LOW_WIN_END),
    .WIN_BASE   (WIN_BASE),
    .WIN_END    (WIN_END)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .hostRd     (hostRd),
    .hostWrData (hostWrData),
    .hostRdData (hostRdData),
    .startPage  (startPage),
    .stopPage   (stopPage),
    .regData    (regData),
    .addrLoLd   (addrLoLd),
    .addrHiLd   (addrHiLd),
    .cntLoLd    (cntLoLd),
    .cntHiLd    (cntHiLd),
    .memAddr    (memAddr),
    .memRdEn    (memRdEn),
    .memWrEn    (memWrEn),
    .memByteEn  (memByteEn),
    .memWrData  (memWrData),
    .memRdData  (memRdData),
    .curAddr    (curAddr),
    .curCount   (curCount)
  );

  AST_NO_WRITE_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && curCount == '0) |-> !memWrEn) // R4
    else $error("memory written with zero count");

  AST_START_ZERO_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStart && !hostRd && !hostWr && !anyLoad && curCount == '0) |=> dmaDone) // R7
    else $error("zero-length start gave no pulse");

endmodule

// File: tb/sim_rdma_port_engine.sv
`timescale 1ns/1ps
module sim_rdma_port_engine;

  logic        clk = 1'b0;
  logic        rstN;
  logic        hostRd, hostWr, hostWide32, cfgWordMode, cmdStart;
  logic [31:0] hostWrData, hostRdData, memWrData, memRdData;
  logic [7:0]  startPage, stopPage, regData;
  logic        addrLoLd, addrHiLd, cntLoLd, cntHiLd;
  logic [15:0] memAddr, curAddr, curCount;
  logic        memRdEn, memWrEn, dmaDone;
  logic [3:0]  memByteEn;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  localparam logic [31:0] WD = 32'hC3B2A190;

  always #2.5 clk = ~clk;

  rdma_port_engine u0 (
    .clk(clk), .rstN(rstN), .hostRd(hostRd), .hostWr(hostWr),
    .hostWide32(hostWide32), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .cfgWordMode(cfgWordMode), .startPage(startPage), .stopPage(stopPage),
    .regData(regData), .addrLoLd(addrLoLd), .addrHiLd(addrHiLd),
    .cntLoLd(cntLoLd), .cntHiLd(cntHiLd), .cmdStart(cmdStart),
    .memAddr(memAddr), .memRdEn(memRdEn), .memWrEn(memWrEn),
    .memByteEn(memByteEn), .memWrData(memWrData), .memRdData(memRdData),
    .curAddr(curAddr), .curCount(curCount), .dmaDone(dmaDone)
  );

  // memory model: byte at address a reads as a[7:0] ^ 8'hA5
  always_comb begin
    for (int i = 0; i < 4; i++)
      memRdData[i*8 +: 8] = 8'(memAddr + 16'(i)) ^ 8'hA5;
  end

  typedef struct packed {
    logic [1:0]  mode;   // 0 byte, 1 word mode, 2 32-bit access
    logic        wr;
    logic [15:0] addr;
    logic [15:0] cnt;
    logic [15:0] eAddr;
    logic [15:0] eCnt;
    logic        eDone;
    logic        eWin;
    logic        eWe;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 16'h4000, 16'd5,  16'h4001, 16'd4, 1'b0, 1'b1, 1'b0}, // R2 byte read
    '{2'd1, 1'b0, 16'h4010, 16'd6,  16'h4012, 16'd4, 1'b0, 1'b1, 1'b0}, // R2 word read
    '{2'd2, 1'b1, 16'h4020, 16'd8,  16'h4024, 16'd4, 1'b0, 1'b1, 1'b1}, // R2 long write
    '{2'd1, 1'b1, 16'h4031, 16'd10, 16'h4033, 16'd8, 1'b0, 1'b1, 1'b1}, // R3 odd word write
    '{2'd0, 1'b1, 16'h7FFF, 16'd3,  16'h4000, 16'd2, 1'b0, 1'b1, 1'b1}, // R5 byte wrap
    '{2'd1, 1'b0, 16'h7FFE, 16'd4,  16'h4000, 16'd2, 1'b0, 1'b1, 1'b0}, // R5 word wrap
    '{2'd2, 1'b0, 16'h7FFC, 16'd4,  16'h4000, 16'd0, 1'b1, 1'b1, 1'b0}, // R5 R6 long wrap, last
    '{2'd0, 1'b0, 16'h0010, 16'd2,  16'h0011, 16'd1, 1'b0, 1'b1, 1'b0}, // R8 low region
    '{2'd1, 1'b0, 16'h0100, 16'd2,  16'h0102, 16'd0, 1'b1, 1'b0, 1'b0}, // R8 gap read
    '{2'd2, 1'b1, 16'hC000, 16'd9,  16'hC004, 16'd5, 1'b0, 1'b0, 1'b0}, // R8 above region
    '{2'd0, 1'b1, 16'h4040, 16'd0,  16'h4040, 16'd0, 1'b0, 1'b1, 1'b0}, // R4 zero write
    '{2'd0, 1'b0, 16'h4050, 16'd0,  16'h4051, 16'd0, 1'b1, 1'b1, 1'b0}, // R10 zero read
    '{2'd2, 1'b0, 16'hBFFC, 16'd3,  16'hC000, 16'd0, 1'b1, 1'b1, 1'b0}, // R6 short count
    '{2'd1, 1'b1, 16'h001F, 16'd1,  16'h0021, 16'd0, 1'b1, 1'b1, 1'b1}, // R3 R6 odd low
    '{2'd0, 1'b0, 16'h3FFF, 16'd7,  16'h4000, 16'd6, 1'b0, 1'b0, 1'b0}  // R8 below region
  };

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  function automatic int beatOf(input logic [1:0] mode);
    return (mode == 2'd2) ? 4 : (mode == 2'd1) ? 2 : 1;
  endfunction

  function automatic logic [31:0] widthMask(input logic [1:0] mode);
    return (mode == 2'd2) ? 32'hFFFF_FFFF : (mode == 2'd1) ? 32'h0000_FFFF : 32'h0000_00FF;
  endfunction

  function automatic logic [31:0] expRead(input logic [1:0] mode, input logic [15:0] a, input bit win);
    logic [31:0] r = '0;
    logic [15:0] al = (mode == 2'd0) ? a : {a[15:1], 1'b0};
    for (int i = 0; i < 4; i++)
      if (i < beatOf(mode)) r[i*8 +: 8] = win ? (8'(al + 16'(i)) ^ 8'hA5) : 8'hFF;
    return r;
  endfunction

  task automatic loadByte(input int which, input logic [7:0] v);
    @(negedge clk);
    regData = v;
    addrLoLd = (which == 0); addrHiLd = (which == 1);
    cntLoLd  = (which == 2); cntHiLd  = (which == 3);
    @(posedge clk); #1;
    {addrLoLd, addrHiLd, cntLoLd, cntHiLd} = '0;
  endtask

  task automatic setup(input logic [15:0] a, input logic [15:0] c);
    loadByte(0, a[7:0]); loadByte(1, a[15:8]);
    loadByte(2, c[7:0]); loadByte(3, c[15:8]);
  endtask

  task automatic runVec(input vec_t v);
    logic [15:0] al;
    al = (v.mode == 2'd0) ? v.addr : {v.addr[15:1], 1'b0};
    setup(v.addr, v.cnt);
    @(negedge clk);
    cfgWordMode = (v.mode == 2'd1);
    hostWide32  = (v.mode == 2'd2);
    hostWr = v.wr; hostRd = !v.wr;
    hostWrData = WD;
    #1;
    if (v.wr) begin
      chk(memWrEn == v.eWe, "R4 R8 memWrEn", 32'(memWrEn), 32'(v.eWe));
      if (v.eWe) begin
        chk(memAddr == al, "R3 aligned memAddr", 32'(memAddr), 32'(al));
        chk(32'(memByteEn) == widthMask(v.mode) >> 28 + 0 || memByteEn == 4'((1 << beatOf(v.mode)) - 1),
            "R3 byte enables", 32'(memByteEn), 32'((1 << beatOf(v.mode)) - 1));
        chk(memWrData == (WD & widthMask(v.mode)), "R3 write lanes", memWrData, WD & widthMask(v.mode));
      end
    end else begin
      chk(hostRdData == expRead(v.mode, v.addr, v.eWin), "R3 R8 read data",
          hostRdData, expRead(v.mode, v.addr, v.eWin));
    end
    @(posedge clk); #1;
    hostRd = 1'b0; hostWr = 1'b0;
    chk(curAddr == v.eAddr, "R2 R5 next address", 32'(curAddr), 32'(v.eAddr));
    chk(curCount == v.eCnt, "R2 R6 next count", 32'(curCount), 32'(v.eCnt));
    chk(dmaDone == v.eDone, "R6 R10 done pulse", 32'(dmaDone), 32'(v.eDone));
    @(posedge clk); #1;
    chk(dmaDone == 1'b0, "R6 pulse one cycle", 32'(dmaDone), 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    {hostRd, hostWr, hostWide32, cfgWordMode, cmdStart} = '0;
    {addrLoLd, addrHiLd, cntLoLd, cntHiLd} = '0;
    hostWrData = '0; regData = '0;
    startPage = 8'h40; stopPage = 8'h80;
    repeat (3) @(posedge clk);
    #1;
    chk(curAddr == 16'h0, "R1 reset address", 32'(curAddr), 32'h0);
    chk(curCount == 16'h0, "R1 reset count", 32'(curCount), 32'h0);
    chk(dmaDone == 1'b0, "R1 reset done", 32'(dmaDone), 32'h0);
    chk(memWrEn == 1'b0, "R1 reset write", 32'(memWrEn), 32'h0);
    @(negedge clk); rstN = 1'b1;

    for (int k = 0; k < NV; k++) runVec(VECS[k]);

    // R9: byte loads keep the other byte
    setup(16'h1234, 16'h0A0B);
    chk(curAddr == 16'h1234, "R9 address load", 32'(curAddr), 32'h1234);
    chk(curCount == 16'h0A0B, "R9 count load", 32'(curCount), 32'h0A0B);
    loadByte(0, 8'h56);
    chk(curAddr == 16'h1256, "R9 low byte only", 32'(curAddr), 32'h1256);
    loadByte(3, 8'h7C);
    chk(curCount == 16'h7C0B, "R9 high byte only", 32'(curCount), 32'h7C0B);
    chk(curAddr == 16'h1256, "R9 address untouched", 32'(curAddr), 32'h1256);

    // R7: start with nonzero count gives no pulse
    @(negedge clk); cmdStart = 1'b1;
    @(posedge clk); #1; cmdStart = 1'b0;
    chk(dmaDone == 1'b0, "R7 start with count", 32'(dmaDone), 32'h0);
    // R7: start with zero count pulses
    setup(16'h4000, 16'h0000);
    @(negedge clk); cmdStart = 1'b1;
    @(posedge clk); #1; cmdStart = 1'b0;
    chk(dmaDone == 1'b1, "R7 zero-length start", 32'(dmaDone), 32'h1);
    @(posedge clk); #1;
    chk(dmaDone == 1'b0, "R7 pulse drops", 32'(dmaDone), 32'h0);

    // R4: a run of writes after the count is used up changes nothing
    setup(16'h5000, 16'h0001);
    @(negedge clk); cfgWordMode = 1'b0; hostWide32 = 1'b0; hostWr = 1'b1;
    @(posedge clk); #1;
    chk(curCount == 16'h0, "R6 count reaches zero", 32'(curCount), 32'h0);
    chk(memWrEn == 1'b0, "R4 no write at zero", 32'(memWrEn), 32'h0);
    @(posedge clk); #1; hostWr = 1'b0;
    chk(curAddr == 16'h5001, "R4 address held", 32'(curAddr), 32'h5001);
    chk(dmaDone == 1'b0, "R4 no extra pulse", 32'(dmaDone), 32'h0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule